// File: doc/BRIEF.md
# Pin Controller with Both-Edge Change Capture

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software programs each pin as input or output, sets output levels through a masked data write, reads back pin levels, and is told about activity on the pins through a single level-sensitive interrupt line. The pin count is a parameter; register bits at or above it do not exist.

Every pin input passes through a two-stage synchronizer. A third stage keeps the previous synchronized value, and any difference between the two, whether rising or falling, latches a pending bit in the change register. Software clears pending bits by writing ones to them. The interrupt line is high while any pending bit is also enabled. The register port is a plain synchronous select/write-enable interface with a registered read return; bus bridging, pads and interrupt routing sit outside the block.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After a synchronous reset every pin is an input (`pin_oe` all zero), `pin_out` is zero, `irq` is low, the write-mask register reads all ones over the implemented pins and every other register reads zero.
- R2: The direction register at byte offset 0x00 reads back as written; bit n of `pin_oe` equals bit n of that register (1 = output, 0 = input), independently per pin.
- R3: A write to the data register at 0x04 changes only those `pin_out` bits whose write-mask bit (register at 0x10) is 1; the other bits keep their value.
- R4: Reading offset 0x04 returns, for each pin, the driven level when the pin is an output and the synchronized `pin_in` level when it is an input.
- R5: Both a rising and a falling transition of a `pin_in` bit set that pin's bit in the change register at 0x0C; the bit is set at the third rising clock edge after the input changes.
- R6: Writing the change register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq` is high exactly while some change bit is set whose bit in the interrupt-enable register at 0x08 is 1.
- R8: When a clearing write to a change bit and a new transition on that pin land in the same cycle, the bit stays set.
- R9: Register bits at or above `N_PINS` read zero and ignore writes; offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero and writes to them change nothing.
- R10: The interrupt-type register at 0x14 reads back as written and does not alter change detection, which is always both-edge.
- R11: Read data appears on `bus_rdata` one cycle after a read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | N_PINS | Pin levels from the pads |
| pin_out | output | N_PINS | Driven pin levels |
| pin_oe | output | N_PINS | Output enables, 1 = drive |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the collision of a clearing write with a fresh transition on the same pin; a design that let the clear win would lose that event and leave the line low. It checks that a falling edge registers as well as a rising one, which a rise-only detector would miss, and it samples the interrupt one cycle before and at the cycle the change bit must appear, exposing a missing or extra synchronizer stage. Masked data writes, written-zero bits of the change register, bits above the pin count and unmapped offsets are read back to catch designs that write through the mask, clear on zero, or store bits that do not exist.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int ADDR_W   = 5;
    localparam int WORD_W   = 32;
    localparam int MAX_PINS = 32;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DIR   = 5'h00,
        OFF_DATA  = 5'h04,
        OFF_IEN   = 5'h08,
        OFF_CHG   = 5'h0C,
        OFF_WMASK = 5'h10,
        OFF_ITYPE = 5'h14
    } reg_off_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_write(bus_req_t r, reg_off_e off);
        return r.sel && r.we && (r.addr == off);
    endfunction

    function automatic logic is_read(bus_req_t r);
        return r.sel && !r.we;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_chg_pkg::*;
#(
    parameter int N_PINS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] raw_i,
    output logic [N_PINS-1:0] sync_o,
    output logic [N_PINS-1:0] edge_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [DEPTH-1:0] stage_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
            end else begin
                stage_q <= {stage_q[DEPTH-2:0], raw_i[p]};
            end
        end

        assign sync_o[p] = stage_q[SYNC_STAGES-1];
        assign edge_o[p] = stage_q[SYNC_STAGES-1] ^ stage_q[SYNC_STAGES];
    end

endmodule

// File: rtl/gpio_change_cap.sv
module gpio_change_cap #(
    parameter int N_PINS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] edge_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] chg_o
);
    logic [N_PINS-1:0] chg_q;

    for (genvar p = 0; p < N_PINS; p++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                chg_q[p] <= 1'b0;
            end else if (edge_i[p]) begin
                chg_q[p] <= 1'b1;
            end else if (clr_i[p]) begin
                chg_q[p] <= 1'b0;
            end
        end
    end

    assign chg_o = chg_q;

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_chg_pkg::*;
#(
    parameter int N_PINS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [N_PINS-1:0] sync_i,
    input  logic [N_PINS-1:0] chg_i,
    output logic [N_PINS-1:0] dir_o,
    output logic [N_PINS-1:0] dout_o,
    output logic [N_PINS-1:0] ien_o,
    output logic [N_PINS-1:0] wmask_o,
    output logic [N_PINS-1:0] clr_o,
    output logic [WORD_W-1:0] rdata_o
);
    logic [N_PINS-1:0] dir_q, dout_q, ien_q, wmask_q, itype_q;
    logic [N_PINS-1:0] wbits;
    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] rd_sel;
    logic [WORD_W-1:0] rdata_q;

    assign wbits = req_i.wdata[N_PINS-1:0];
    assign level = (dout_q & dir_q) | (sync_i & ~dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            dout_q  <= '0;
            ien_q   <= '0;
            wmask_q <= '1;
            itype_q <= '0;
        end else begin
            if (is_write(req_i, OFF_DIR))   dir_q   <= wbits;
            if (is_write(req_i, OFF_DATA))  dout_q  <= (dout_q & ~wmask_q) | (wbits & wmask_q);
            if (is_write(req_i, OFF_IEN))   ien_q   <= wbits;
            if (is_write(req_i, OFF_WMASK)) wmask_q <= wbits;
            if (is_write(req_i, OFF_ITYPE)) itype_q <= wbits;
        end
    end

    assign clr_o = is_write(req_i, OFF_CHG) ? wbits : '0;

    always_comb begin
        case (req_i.addr)
            OFF_DIR:   rd_sel = dir_q;
            OFF_DATA:  rd_sel = level;
            OFF_IEN:   rd_sel = ien_q;
            OFF_CHG:   rd_sel = chg_i;
            OFF_WMASK: rd_sel = wmask_q;
            OFF_ITYPE: rd_sel = itype_q;
            default:   rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (is_read(req_i)) begin
            rdata_q <= WORD_W'(rd_sel);
        end
    end

    assign dir_o   = dir_q;
    assign dout_o  = dout_q;
    assign ien_o   = ien_q;
    assign wmask_o = wmask_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
    import gpio_chg_pkg::*;
#(
    parameter int N_PINS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    bus_req_t          req;
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] pin_edge;
    logic [N_PINS-1:0] chg_bits;
    logic [N_PINS-1:0] clr_bits;
    logic [N_PINS-1:0] ien_bits;
    logic [N_PINS-1:0] wmask_bits;

    assign req = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    gpio_pin_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pin_in),
        .sync_o (pin_sync),
        .edge_o (pin_edge)
    );

    gpio_change_cap #(.N_PINS(N_PINS)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .edge_i (pin_edge),
        .clr_i  (clr_bits),
        .chg_o  (chg_bits)
    );

    gpio_regbank #(.N_PINS(N_PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .sync_i  (pin_sync),
        .chg_i   (chg_bits),
        .dir_o   (pin_oe),
        .dout_o  (pin_out),
        .ien_o   (ien_bits),
        .wmask_o (wmask_bits),
        .clr_o   (clr_bits),
        .rdata_o (bus_rdata)
    );

    assign irq = |(chg_bits & ien_bits);

endmodule

// File: rtl/gpio_chg_ctrl_chk.sv
module gpio_chg_ctrl_chk
    import gpio_chg_pkg::*;
#(
    parameter int N_PINS = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [4:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] edge_v,
    input logic [N_PINS-1:0] chg,
    input logic [N_PINS-1:0] ien,
    input logic [N_PINS-1:0] wmask
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && pin_oe == '0 && pin_out == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == OFF_DIR) |=> pin_oe == $past(bus_wdata[N_PINS-1:0]));

    assert_data_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == OFF_DATA) |=>
            pin_out == (($past(pin_out) & ~$past(wmask)) | ($past(bus_wdata[N_PINS-1:0]) & $past(wmask))));

    assert_chg_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (edge_v == '0) |=> ((chg & ~$past(chg)) == '0));

    assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien != '0));

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (edge_v != '0) |=> ((chg & $past(edge_v)) == $past(edge_v)));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

    if (N_PINS < 32) begin : g_upper
        assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
            bus_rdata[31:N_PINS] == '0);
    end

endmodule

bind gpio_chg_ctrl gpio_chg_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .edge_v    (pin_edge),
    .chg       (chg_bits),
    .ien       (ien_bits),
    .wmask     (wmask_bits)
);

// File: tb/gpio_chg_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_chg_ctrl_tb;
    localparam int N = 24;
    localparam logic [31:0] PMASK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_chg_ctrl #(.N_PINS(N)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // entries: {offset[7:0], write value[31:0], expected readback[31:0]}
    localparam logic [71:0] VEC [6] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h00FF_FFFF},   // R2 R9
        {8'h08, 32'h1234_5678, 32'h0034_5678},   // R9
        {8'h14, 32'hA5A5_A5A5, 32'h00A5_A5A5},   // R10
        {8'h10, 32'h0000_FFFF, 32'h0000_FFFF},   // R3
        {8'h04, 32'hFFFF_FFFF, 32'h0000_FFFF},   // R3 R4
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000}    // R9
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        do_reset();

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(5'h10, v); check("R1 wmask", v, PMASK);
        rd(5'h0C, v); check("R1 change", v, 32'h0);
        rd(5'h08, v); check("R1 enable", v, 32'h0);

        // register table (R2 R3 R4 R9 R10)
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], v);
            check($sformatf("table entry %0d", i), v, VEC[i][31:0]);
        end
        check("R3 masked pin_out", 32'(pin_out), 32'h0000_FFFF);

        do_reset();

        // R2 direction to pin_oe
        wr(5'h00, 32'h0000_0F0F);
        check("R2 pin_oe", 32'(pin_oe), 32'h0000_0F0F);

        // R3 masked data writes
        wr(5'h10, 32'h0000_00FF);
        wr(5'h04, 32'hFFFF_FFFF);
        check("R3 partial mask", 32'(pin_out), 32'h0000_00FF);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h04, 32'h0000_A5A5);
        check("R3 full mask", 32'(pin_out), 32'h0000_A5A5);

        // R4 mixed read of levels
        pin_in = 24'h12_3456;
        settle(4);
        rd(5'h04, v);
        check("R4 level read", v, (32'h0000_A5A5 & 32'h0F0F) | (32'h0012_3456 & ~32'h0F0F & PMASK));
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R6 clear all", v, 32'h0);

        // R5 rising edge timing, R7 irq
        wr(5'h08, 32'h0000_0001);
        @(negedge clk);
        pin_in = 24'h12_3457;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R5 not before third edge", 32'(irq), 32'h0);
        @(negedge clk);
        check("R5 R7 irq on rise", 32'(irq), 32'h1);
        rd(5'h0C, v); check("R5 change rise", v, 32'h1);

        // R6 write zero keeps, write one clears
        wr(5'h0C, 32'h0000_0000);
        rd(5'h0C, v); check("R6 zero keeps", v, 32'h1);
        wr(5'h0C, 32'h0000_0001);
        rd(5'h0C, v); check("R6 one clears", v, 32'h0);
        check("R7 irq after clear", 32'(irq), 32'h0);

        // R5 falling edge
        pin_in = 24'h12_3456;
        settle(4);
        rd(5'h0C, v); check("R5 change fall", v, 32'h1);
        check("R7 irq on fall", 32'(irq), 32'h1);

        // R7 masked pending
        wr(5'h08, 32'h0000_0000);
        check("R7 masked irq", 32'(irq), 32'h0);

        // R8 clear colliding with a new edge
        @(negedge clk);
        pin_in = 24'h12_3457;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(5'h0C, v); check("R8 edge wins", v, 32'h1);
        wr(5'h0C, 32'h0000_0001);
        rd(5'h0C, v); check("R8 later clear", v, 32'h0);

        // R10 type register leaves both-edge detection
        wr(5'h14, 32'h00FF_FFFF);
        pin_in = 24'h12_3453;
        settle(4);
        rd(5'h0C, v); check("R10 detection unchanged", v, 32'h4);

        // R11 read data hold
        rd(5'h00, v);
        held = bus_rdata;
        check("R11 read value", v, 32'h0000_0F0F);
        wr(5'h08, 32'h0000_0003);
        settle(3);
        check("R11 hold", bus_rdata, held);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule